// File: doc/BRIEF.md
# Single-Wire Brightness Command Receiver

This block receives brightness commands that a host sends over a single wire once single-wire control has been selected. It works on a synchronized sample of the line, a reset and a timebase tick. Each bit opens at a falling edge of the line, spends a low phase and then a high phase, and closes at the next falling edge. The receiver counts both phases in timebase ticks and decides the bit value from the ratio of the two counts. Because only the ratio matters, the host may send at any rate from roughly 1.7 kbit/s up to 160 kbit/s with no configuration.

Twenty-four bits make one frame, least significant bit first. The first sixteen form a data field and the last eight an address field. When every bit was decoded cleanly and the address matches, the 9-bit brightness code is taken from the data field and committed in one step, together with a one-cycle strobe. If the frame also asks for an acknowledge, the block waits a fixed delay and then pulls the line low through an open-drain enable for a fixed time. A phase that lasts too long abandons the frame and returns the receiver to idle.

Top module: `swr_bright_rx`

## Requirements
- R1: While reset is asserted and after it is released, `level_o` reads 511 (all ones), `frame_ok_o` is 0 and `ack_pull_o` is 0.
- R2: A bit whose low count is at least twice its high count decodes as 0. A bit whose high count is at least twice its low count decodes as 1.
- R3: The received bits are numbered 0 to 23 in order of arrival. Bits 0..15 are the data field and bits 16..23 the address, each least significant bit first. With address 0x8F and every bit valid, the falling edge that closes bit 23 commits data bits 8..0 to `level_o` and raises `frame_ok_o`, both visible one clock after the edge that samples that falling edge.
- R4: A frame whose address differs from 0x8F leaves `level_o` unchanged and gives no strobe and no acknowledge.
- R5: If any bit of a frame meets neither ratio rule, the whole frame is discarded: no update, no strobe, no acknowledge.
- R6: When a committed frame has data bit 10 set, `ack_pull_o` rises ACK_DELAY_TICKS ticks after the commit edge and stays high for exactly ACK_LEN_TICKS ticks. It never coincides with `frame_ok_o`.
- R7: A committed frame with data bit 10 clear produces no acknowledge.
- R8: If a low or a high phase inside a frame reaches TIMEOUT_TICKS ticks, the partial frame is dropped and the bit count restarts. A complete frame sent afterwards decodes correctly.
- R9: From idle, a falling edge begins a frame only if the line was high for at least START_TICKS ticks just before it. Otherwise the edge is ignored.
- R10: The same frame sent with short phases of 1 tick and of 40 ticks decodes to the same code.
- R11: Data bit 9 and data bits 15..11 do not affect the committed code.
- R12: `frame_ok_o` is high for a single cycle, and `level_o` changes only in a cycle where `frame_ok_o` is high.
- R13: Phase counters advance only on cycles with `tick_i` high. A frame whose phases last longer than TIMEOUT_TICKS clock cycles but fewer ticks decodes normally when the tick runs at half the clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Timebase pulse that advances the phase and acknowledge counters |
| line_i | input | 1 | Synchronized sample of the single-wire line |
| level_o | output | 9 | Committed brightness code |
| frame_ok_o | output | 1 | One-cycle strobe on each commit |
| ack_pull_o | output | 1 | Enable for the open-drain pull-down of the line |

## Verification
A falling edge is seen at the first clock edge that samples the line low. The strobe and the new code appear one cycle later, so the bench samples them at the first falling clock edge after the closing edge, and checks at the next one that the strobe has dropped again. With the tick running every cycle, the acknowledge first shows at the (ACK_DELAY_TICKS+1)-th sample after the closing edge and lasts ACK_LEN_TICKS samples, and the bench counts both in a window after every frame. Reset reaches the code register at once through the asynchronous path and is released two cycles after `rst_n` rises, so reset checks are sampled inside the reset and several cycles after it.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int unsigned FRAME_LEN   = 24;
  localparam int unsigned DATA_LEN    = 16;
  localparam int unsigned ADDR_W      = FRAME_LEN - DATA_LEN;
  localparam int unsigned LEVEL_W     = 9;
  localparam int unsigned ACK_REQ_POS = 10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_WAIT,
    ST_ACK_DRV
  } swr_state_e;
endpackage

// File: rtl/swr_line_edge.sv
module swr_line_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic fall_o
);
  logic line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_i;
  end

  assign fall_o = line_q & ~line_i;
endmodule

// File: rtl/swr_phase_cnt.sv
module swr_phase_cnt #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             line_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] lo_q, lo_d, hi_q, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (clr_i) begin
      lo_d = '0;
      hi_d = '0;
    end else if (tick_i) begin
      if (line_i) hi_d = (hi_q == CNT_MAX) ? hi_q : hi_q + 1'b1;
      else        lo_d = (lo_q == CNT_MAX) ? lo_q : lo_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/swr_bit_class.sv
module swr_bit_class #(
  parameter int unsigned CNT_W = 9
) (
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             val_o,
  output logic             ok_o
);
  logic is_zero, is_one;

  always_comb begin
    is_zero = {1'b0, lo_i} >= {hi_i, 1'b0};
    is_one  = {1'b0, hi_i} >= {lo_i, 1'b0};
    val_o   = is_one;
    ok_o    = is_zero ^ is_one;
  end
endmodule

// File: rtl/swr_frame_fsm.sv
module swr_frame_fsm
  import swr_pkg::*;
#(
  parameter int unsigned       CNT_W           = 9,
  parameter int unsigned       TIMEOUT_TICKS   = 400,
  parameter int unsigned       START_TICKS     = 2,
  parameter int unsigned       ACK_DELAY_TICKS = 4,
  parameter int unsigned       ACK_LEN_TICKS   = 512,
  parameter logic [ADDR_W-1:0] DEV_ADDR        = 8'h8F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               line_i,
  input  logic               fall_i,
  input  logic [CNT_W-1:0]   lo_i,
  input  logic [CNT_W-1:0]   hi_i,
  input  logic               bit_val_i,
  input  logic               bit_ok_i,
  output logic               clr_o,
  output logic [LEVEL_W-1:0] level_o,
  output logic               frame_ok_o,
  output logic               ack_pull_o
);
  localparam int unsigned ACK_MAX = (ACK_DELAY_TICKS > ACK_LEN_TICKS) ? ACK_DELAY_TICKS : ACK_LEN_TICKS;
  localparam int unsigned ACK_W   = $clog2(ACK_MAX + 1);
  localparam int unsigned IDX_W   = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TO_LIM    = CNT_W'(TIMEOUT_TICKS);
  localparam logic [CNT_W-1:0] START_LIM = CNT_W'(START_TICKS);
  localparam logic [ACK_W-1:0] DLY_END   = ACK_W'(ACK_DELAY_TICKS - 1);
  localparam logic [ACK_W-1:0] LEN_END   = ACK_W'(ACK_LEN_TICKS - 1);

  swr_state_e         st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               bad_q, bad_d;
  logic [LEVEL_W-1:0] lacc_q, lacc_d, lacc_w;
  logic               racc_q, racc_d, racc_w;
  logic [ADDR_W-1:0]  aacc_q, aacc_d, aacc_w;
  logic [LEVEL_W-1:0] lvl_q, lvl_d;
  logic               fok_q, fok_d;
  logic [ACK_W-1:0]   acnt_q, acnt_d;
  logic               bad_now;

  // Only the fields that matter are stored; the current bit is merged in place.
  always_comb begin
    lacc_w = lacc_q;
    racc_w = racc_q;
    aacc_w = aacc_q;
    for (int i = 0; i < LEVEL_W; i++)
      if (idx_q == IDX_W'(i)) lacc_w[i] = bit_val_i;
    if (idx_q == IDX_W'(ACK_REQ_POS)) racc_w = bit_val_i;
    for (int i = 0; i < ADDR_W; i++)
      if (idx_q == IDX_W'(DATA_LEN + i)) aacc_w[i] = bit_val_i;
    bad_now = bad_q | ~bit_ok_i;
  end

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    bad_d  = bad_q;
    lacc_d = lacc_q;
    racc_d = racc_q;
    aacc_d = aacc_q;
    lvl_d  = lvl_q;
    fok_d  = 1'b0;
    acnt_d = acnt_q;
    clr_o  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        clr_o = ~line_i;
        if (fall_i && (hi_i >= START_LIM)) begin
          st_d  = ST_RX;
          idx_d = '0;
          bad_d = 1'b0;
        end
      end
      ST_RX: begin
        if (fall_i) begin
          clr_o  = 1'b1;
          bad_d  = bad_now;
          lacc_d = lacc_w;
          racc_d = racc_w;
          aacc_d = aacc_w;
          if (idx_q == LAST_IDX) begin
            st_d  = ST_IDLE;
            idx_d = '0;
            if (!bad_now && (aacc_w == DEV_ADDR)) begin
              lvl_d = lacc_w;
              fok_d = 1'b1;
              if (racc_w) begin
                st_d   = ST_ACK_WAIT;
                acnt_d = '0;
              end
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else if ((lo_i >= TO_LIM) || (hi_i >= TO_LIM)) begin
          st_d  = ST_IDLE;
          idx_d = '0;
          clr_o = 1'b1;
        end
      end
      ST_ACK_WAIT: begin
        clr_o = 1'b1;
        if (tick_i) begin
          if (acnt_q == DLY_END) begin
            st_d   = ST_ACK_DRV;
            acnt_d = '0;
          end else begin
            acnt_d = acnt_q + 1'b1;
          end
        end
      end
      ST_ACK_DRV: begin
        clr_o = 1'b1;
        if (tick_i) begin
          if (acnt_q == LEN_END) begin
            st_d   = ST_IDLE;
            acnt_d = '0;
          end else begin
            acnt_d = acnt_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      bad_q  <= 1'b0;
      lacc_q <= '0;
      racc_q <= 1'b0;
      aacc_q <= '0;
      lvl_q  <= '1;
      fok_q  <= 1'b0;
      acnt_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      bad_q  <= bad_d;
      lacc_q <= lacc_d;
      racc_q <= racc_d;
      aacc_q <= aacc_d;
      lvl_q  <= lvl_d;
      fok_q  <= fok_d;
      acnt_q <= acnt_d;
    end
  end

  assign level_o    = lvl_q;
  assign frame_ok_o = fok_q;
  assign ack_pull_o = (st_q == ST_ACK_DRV);
endmodule

// File: rtl/swr_bright_rx.sv
module swr_bright_rx
  import swr_pkg::*;
#(
  parameter int unsigned       TIMEOUT_TICKS   = 400,
  parameter int unsigned       START_TICKS     = 2,
  parameter int unsigned       ACK_DELAY_TICKS = 4,
  parameter int unsigned       ACK_LEN_TICKS   = 512,
  parameter logic [ADDR_W-1:0] DEV_ADDR        = 8'h8F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               line_i,
  output logic [LEVEL_W-1:0] level_o,
  output logic               frame_ok_o,
  output logic               ack_pull_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_TICKS + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             fall_w;
  logic             clr_w;
  logic [CNT_W-1:0] lo_w, hi_w;
  logic             bit_val_w, bit_ok_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  swr_line_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .line_i (line_i),
    .fall_o (fall_w)
  );

  swr_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .tick_i (tick_i),
    .line_i (line_i),
    .clr_i  (clr_w),
    .lo_o   (lo_w),
    .hi_o   (hi_w)
  );

  swr_bit_class #(.CNT_W(CNT_W)) u_class (
    .lo_i  (lo_w),
    .hi_i  (hi_w),
    .val_o (bit_val_w),
    .ok_o  (bit_ok_w)
  );

  swr_frame_fsm #(
    .CNT_W           (CNT_W),
    .TIMEOUT_TICKS   (TIMEOUT_TICKS),
    .START_TICKS     (START_TICKS),
    .ACK_DELAY_TICKS (ACK_DELAY_TICKS),
    .ACK_LEN_TICKS   (ACK_LEN_TICKS),
    .DEV_ADDR        (DEV_ADDR)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .tick_i     (tick_i),
    .line_i     (line_i),
    .fall_i     (fall_w),
    .lo_i       (lo_w),
    .hi_i       (hi_w),
    .bit_val_i  (bit_val_w),
    .bit_ok_i   (bit_ok_w),
    .clr_o      (clr_w),
    .level_o    (level_o),
    .frame_ok_o (frame_ok_o),
    .ack_pull_o (ack_pull_o)
  );
endmodule

// File: rtl/swr_rx_checker.sv
module swr_rx_checker #(
  parameter int unsigned ACK_LEN_TICKS = 512
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [8:0] level,
  input logic       frame_ok,
  input logic       ack_pull,
  input logic       fall
);
  logic [31:0] ack_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ack_ticks <= '0;
    else if (!ack_pull) ack_ticks <= '0;
    else if (tick)     ack_ticks <= ack_ticks + 1'b1;
  end

  p_level_needs_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> frame_ok);

  p_strobe_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);

  p_strobe_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> $past(fall));

  p_ack_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pull |-> (ack_ticks < 32'(ACK_LEN_TICKS)));

  p_ack_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && ack_pull));
endmodule

bind swr_bright_rx swr_rx_checker #(.ACK_LEN_TICKS(ACK_LEN_TICKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .tick     (tick_i),
  .level    (level_o),
  .frame_ok (frame_ok_o),
  .ack_pull (ack_pull_o),
  .fall     (fall_w)
);

// File: tb/test_swr_bright_rx.sv
module test_swr_bright_rx;
  localparam int TIMEOUT = 200;
  localparam int START   = 4;
  localparam int ADLY    = 6;
  localparam int ALEN    = 40;
  localparam int WIN     = ADLY + ALEN + 10;
  localparam int NVEC    = 9;

  // {frame[23:0], unit[7:0], update, level[8:0]}
  localparam logic [41:0] VEC [NVEC] = '{
    {24'h8F0155, 8'd8,  1'b1, 9'h155},
    {24'h8F00AA, 8'd3,  1'b1, 9'h0AA},
    {24'h8E0500, 8'd5,  1'b0, 9'h0AA},  // R4 wrong address with ack request
    {24'h8FFA33, 8'd5,  1'b1, 9'h033},  // R11 don't-care bits set
    {24'h8F0000, 8'd20, 1'b1, 9'h000},
    {24'h8F0155, 8'd1,  1'b1, 9'h155},  // R10 shortest phases
    {24'h0F01FF, 8'd4,  1'b0, 9'h155},  // R4 address top bit differs
    {24'h8F01FF, 8'd40, 1'b1, 9'h1FF},  // R10 long phases
    {24'h8F0412, 8'd4,  1'b1, 9'h012}   // R6 ack requested
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       drv = 1'b1;
  logic       slow = 1'b0;
  logic       tick_ph = 1'b0;
  logic       tick;
  logic       line;
  logic [8:0] level;
  logic       frame_ok;
  logic       ack_pull;
  int         nchecks = 0;
  int         nfail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) tick_ph <= ~tick_ph;
  assign tick = slow ? tick_ph : 1'b1;
  assign line = drv & ~ack_pull;

  swr_bright_rx #(
    .TIMEOUT_TICKS   (TIMEOUT),
    .START_TICKS     (START),
    .ACK_DELAY_TICKS (ADLY),
    .ACK_LEN_TICKS   (ALEN),
    .DEV_ADDR        (8'h8F)
  ) i_swr_bright_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .line_i     (line),
    .level_o    (level),
    .frame_ok_o (frame_ok),
    .ack_pull_o (ack_pull)
  );

  task automatic chk(input bit c, input string req, input int act, input int exp);
    nchecks++;
    if (!c) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts at a falling clock edge. bad_idx marks a bit sent with an ambiguous ratio.
  task automatic send_frame(input logic [23:0] f, input int u, input int bad_idx,
                            input int lead, input int nbits);
    drv = 1'b1;
    repeat (lead) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      int lo, hi;
      if (b == bad_idx)  begin lo = 3*u; hi = 2*u; end
      else if (f[b])     begin lo = u;   hi = 3*u; end
      else               begin lo = 3*u; hi = u;   end
      drv = 1'b0;
      repeat (lo) @(negedge clk);
      drv = 1'b1;
      repeat (hi) @(negedge clk);
    end
  endtask

  // Drives the closing falling edge, then watches strobe, code and acknowledge.
  task automatic close_and_watch(input bit exp_ok, input logic [8:0] exp_lvl,
                                 input bit exp_ack, input string tag);
    int first = 0;
    int len = 0;
    drv = 1'b0;
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      if (k == 1) begin
        chk(frame_ok == exp_ok, tag, int'(frame_ok), int'(exp_ok));
        chk(level == exp_lvl, tag, int'(level), int'(exp_lvl));
      end
      if (k == 2) chk(!frame_ok, "R12 strobe width", int'(frame_ok), 0);
      if (ack_pull) begin
        if (first == 0) first = k;
        len++;
      end
    end
    if (exp_ack) begin
      chk(first == ADLY + 1, "R6 ack delay", first, ADLY + 1);
      chk(len == ALEN, "R6 ack length", len, ALEN);
    end else begin
      chk(len == 0, "R7 no ack", len, 0);
    end
    drv = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(level == 9'h1FF, "R1 reset level", int'(level), 511);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(level == 9'h1FF, "R1 level after reset", int'(level), 511);
    chk(!frame_ok, "R1 strobe after reset", int'(frame_ok), 0);
    chk(!ack_pull, "R1 ack after reset", int'(ack_pull), 0);

    // R2 R3 R4 decode table
    for (int i = 0; i < NVEC; i++) begin
      logic [41:0] v;
      v = VEC[i];
      send_frame(v[41:18], int'(v[17:10]), -1, 20, 24);
      close_and_watch(v[9], v[8:0], v[9] & v[28],
                      v[9] ? "R3 R2 commit" : "R4 address reject");
    end

    // R5 ambiguous bit in an otherwise good frame
    send_frame(24'h8F0077, 4, 5, 20, 24);
    close_and_watch(1'b0, 9'h012, 1'b0, "R5 invalid bit");

    // R8 low-phase timeout, then a good frame
    send_frame(24'h8F0055, 4, -1, 20, 10);
    drv = 1'b0;
    repeat (TIMEOUT + 20) @(negedge clk);
    send_frame(24'h8F0066, 4, -1, 20, 24);
    close_and_watch(1'b1, 9'h066, 1'b0, "R8 after low timeout");

    // R8 high-phase timeout, the long high also serves as start
    send_frame(24'h8F00F0, 4, -1, 20, 10);
    drv = 1'b1;
    repeat (TIMEOUT + 20) @(negedge clk);
    send_frame(24'h8F0011, 4, -1, 0, 24);
    close_and_watch(1'b1, 9'h011, 1'b0, "R8 after high timeout");

    // R9 too-short high before the first falling edge
    drv = 1'b0;
    repeat (30) @(negedge clk);
    drv = 1'b1;
    repeat (2) @(negedge clk);
    send_frame(24'h8F0123, 4, -1, 0, 24);
    close_and_watch(1'b0, 9'h011, 1'b0, "R9 short start");
    repeat (TIMEOUT + 20) @(negedge clk);
    chk(level == 9'h011, "R9 level kept", int'(level), 17);

    // R13 half-rate tick: phases of 300 cycles stay under the tick timeout
    slow = 1'b1;
    send_frame(24'h8F0199, 100, -1, 20, 24);
    close_and_watch(1'b1, 9'h199, 1'b0, "R13 slow tick");
    slow = 1'b0;

    // R1 reset restores all ones
    send_frame(24'h8F0020, 4, -1, 20, 24);
    close_and_watch(1'b1, 9'h020, 1'b0, "R3 before reset");
    rst_n = 1'b0;
    @(negedge clk);
    chk(level == 9'h1FF, "R1 level in reset", int'(level), 511);
    chk(!frame_ok && !ack_pull, "R1 outputs in reset", int'({frame_ok, ack_pull}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(level == 9'h1FF, "R1 level after re-reset", int'(level), 511);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nfail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end
endmodule